// File: doc/BRIEF.md
# Management Command Mailbox with Alternating Response Slots

This block is a single-outstanding command channel between software and a hardware agent. Software fills a command slot over a simple word bus and writes the first word last. That word holds the verb byte. The hardware tracks the verb's valid bit. When the bit differs from the one it last consumed, the block takes the command, runs a fixed-latency stub executor and places the result in one of two response slots. The slots are used in turn.

A response slot's verb byte reads zero from the moment its command is accepted until the result is complete. Software therefore polls the expected slot until the verb turns nonzero. It then flips the command valid bit for the next command. At startup the command verb's valid bit is clear, so the first result goes to the second response slot, and the next valid bit to send is 1. While a command is executing, the command slot is frozen.

The stub result is:
- the opcode and valid bit in the response verb;
- a running completion count in word 1;
- an echo of the remaining command words.

Top module: `mgmt_cmd_mailbox`

## Requirements
- R1: After reset every word of the command slot and both response slots reads zero. The first accepted command completes into response slot 1.
- R2: A command is accepted only when bit 7 of command word 0 differs from the valid bit of the last accepted command. Rewriting word 0 with an unchanged bit 7 starts nothing and leaves both response slots unchanged.
- R3: When the edge that writes a flipped valid bit is counted as edge 0, the target slot's verb becomes nonzero after edge LATENCY+1.
- R4: Results go alternately to response slot 1, slot 0, slot 1, and so on, one slot per completed command.
- R5: At acceptance, word 0 of the target response slot is cleared. It reads zero until completion, and the other slot keeps its contents.
- R6: The result word 0 holds the command valid bit in bit 7, a 1 in bit 6, the command opcode (command word 0 bits 5:0) in bits 5:0, and zero in all higher bits. The verb is therefore never zero.
- R7: The result word 1 is the number of commands completed since reset, counting the current one. Words 2 and up echo the matching command words. All result words are written on the same edge as the verb.
- R8: Bus writes to the command slot while a command is executing are dropped, and the result echoes the command words as they were at acceptance.
- R9: Bus writes to either response slot are ignored.
- R10: The address is {region, word index}: region 0 is the command slot, 1 is response slot 0, 2 is response slot 1, and 3 reads zero. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Word write strobe |
| busAddr | input | log2(SLOT_WORDS)+2 | Region and word index |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr |

## Verification
The bench builds the block with LATENCY=3, SLOT_WORDS=4 and DATA_W=32. Three busy cycles give a polling window in which the cleared verb is seen several times before the result, so the exact completion edge is measured. Four-word slots leave two echo words, so a write dropped during execution shows up in the echoed payload. A command stream of five entries runs the slot alternation through two full cycles with both valid-bit values. Extreme opcodes and arguments probe the verb encoding.

// File: rtl/mgmt_mbox_pkg.sv
package mgmt_mbox_pkg;

  localparam int VERB_W    = 8;
  localparam int VALID_BIT = 7;
  localparam int DONE_BIT  = 6;
  localparam int OP_W      = 6;

  localparam logic [1:0] REGION_CMD  = 2'd0;
  localparam logic [1:0] REGION_RSP0 = 2'd1;
  localparam logic [1:0] REGION_RSP1 = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;    // take the command in this cycle
    logic complete;  // write the result in this cycle
    logic lock;      // command slot frozen
    logic sel;       // response slot in use
  } mboxStrobe_t;

endpackage

// File: rtl/mgmt_mbox_ctrl.sv
module mgmt_mbox_ctrl
  import mgmt_mbox_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdVbit,
  output mboxStrobe_t strobes
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  typedef enum logic {ST_IDLE, ST_EXEC} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             lastVbit;
  logic             rspSel;
  logic             acceptNow;
  logic             completeNow;

  assign acceptNow   = (state == ST_IDLE) && (cmdVbit != lastVbit);
  assign completeNow = (state == ST_EXEC) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastVbit <= 1'b0;
      rspSel   <= 1'b1;  // clear valid bit at startup selects slot 1
    end else if (acceptNow) begin
      state    <= ST_EXEC;
      cnt      <= CNT_W'(LATENCY - 1);
      lastVbit <= cmdVbit;
    end else if (completeNow) begin
      state    <= ST_IDLE;
      rspSel   <= ~rspSel;
    end else if (state == ST_EXEC) begin
      cnt      <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    strobes.accept   = acceptNow;
    strobes.complete = completeNow;
    strobes.lock     = (state == ST_EXEC);
    strobes.sel      = rspSel;
  end

  // R2: entering execution always consumes a fresh valid bit
  p_fresh_vbit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && $past(state) == ST_IDLE) |-> (lastVbit != $past(lastVbit)));

  // R4: the slot flips on each completion and holds otherwise
  p_alternate_r4: assert property (@(posedge clk) disable iff (!rstN)
    completeNow |=> (rspSel != $past(rspSel)));

  p_hold_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    !completeNow |=> $stable(rspSel));

endmodule

// File: rtl/mgmt_mbox_datapath.sv
module mgmt_mbox_datapath
  import mgmt_mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SLOT_WORDS = 4,
  parameter int ADDR_W     = $clog2(SLOT_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobes,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              cmdVbit
);

  localparam int IDX_W = ADDR_W - 2;

  logic [SLOT_WORDS-1:0][DATA_W-1:0]      cmdMem;
  logic [1:0][SLOT_WORDS-1:0][DATA_W-1:0] rspMem;
  logic [SLOT_WORDS-1:0][DATA_W-1:0]      resultSlot;
  logic [DATA_W-1:0]                      seqCount;
  logic [DATA_W-1:0]                      seqNext;
  logic [1:0]                             region;
  logic [IDX_W-1:0]                       idx;

  assign region  = busAddr[ADDR_W-1:IDX_W];
  assign idx     = busAddr[IDX_W-1:0];
  assign seqNext = seqCount + DATA_W'(1);
  assign cmdVbit = cmdMem[0][VALID_BIT];

  // Command slot: bus-writable only while no command executes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdMem <= '0;
    end else if (busWrEn && region == REGION_CMD && !strobes.lock) begin
      cmdMem[idx] <= busWrData;
    end
  end

  // Stub result, built from the frozen command slot
  for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_result
    if (w == 0) begin : g_verb
      assign resultSlot[w] = DATA_W'({cmdMem[0][VALID_BIT], 1'b1, cmdMem[0][OP_W-1:0]});
    end else if (w == 1) begin : g_seq
      assign resultSlot[w] = seqNext;
    end else begin : g_echo
      assign resultSlot[w] = cmdMem[w];
    end
  end

  // Response slots: written only by the control strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspMem   <= '0;
      seqCount <= '0;
    end else begin
      if (strobes.accept) begin
        rspMem[strobes.sel][0] <= '0;
      end
      if (strobes.complete) begin
        rspMem[strobes.sel] <= resultSlot;
        seqCount            <= seqNext;
      end
    end
  end

  always_comb begin
    case (region)
      REGION_CMD:  busRdData = cmdMem[idx];
      REGION_RSP0: busRdData = rspMem[0][idx];
      REGION_RSP1: busRdData = rspMem[1][idx];
      default:     busRdData = '0;
    endcase
  end

  // R5: the receiving slot's verb is zero right after acceptance
  p_clear_on_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> (rspMem[$past(strobes.sel)][0] == '0));

  // R6: a completed verb is never zero
  p_verb_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.complete |=> (rspMem[$past(strobes.sel)][0][VERB_W-1:0] != '0));

  // R7: payload lands together with the verb and the count advances by one
  p_payload_with_verb_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.complete |=> (rspMem[$past(strobes.sel)][1] == seqCount));

  p_seq_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.complete |=> (seqCount == $past(seqCount) + DATA_W'(1)));

  // R8: command slot frozen during execution
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lock |=> $stable(cmdMem));

  // R9: response slots move only on control strobes
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accept && !strobes.complete) |=> $stable(rspMem));

endmodule

// File: rtl/mgmt_cmd_mailbox.sv
module mgmt_cmd_mailbox
  import mgmt_mbox_pkg::*;
#(
  parameter int   DATA_W     = 32,
  parameter int   SLOT_WORDS = 4,
  parameter int   LATENCY    = 3,
  localparam int  ADDR_W     = $clog2(SLOT_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  mboxStrobe_t strobes;
  logic        cmdVbit;

  mgmt_mbox_ctrl #(
    .LATENCY (LATENCY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdVbit (cmdVbit),
    .strobes (strobes)
  );

  mgmt_mbox_datapath #(
    .DATA_W     (DATA_W),
    .SLOT_WORDS (SLOT_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cmdVbit   (cmdVbit)
  );

endmodule

// File: tb/mgmt_cmd_mailbox_bench.sv
module mgmt_cmd_mailbox_bench;

  localparam int DATA_W     = 32;
  localparam int SLOT_WORDS = 4;
  localparam int LATENCY    = 3;
  localparam int ADDR_W     = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mgmt_cmd_mailbox #(
    .DATA_W     (DATA_W),
    .SLOT_WORDS (SLOT_WORDS),
    .LATENCY    (LATENCY)
  ) u_mgmt_cmd_mailbox (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] arg;
    logic        slot;
    logic [7:0]  verb;
  } vec_t;

  // valid bit alternates 1,0,1,... starting from 1
  localparam vec_t VECS [5] = '{
    '{6'h00, 32'h0000_0000, 1'b1, 8'hC0},
    '{6'h3F, 32'hFFFF_FFFF, 1'b0, 8'h7F},
    '{6'h15, 32'hA5A5_0001, 1'b1, 8'hD5},
    '{6'h2A, 32'h1234_5678, 1'b0, 8'h6A},
    '{6'h01, 32'h8000_0000, 1'b1, 8'hC1}
  };

  function automatic logic [ADDR_W-1:0] ad(input logic [1:0] region, input int w);
    return {region, 2'(w)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic issueCmd(input logic vbit, input logic [5:0] op, input logic [31:0] arg);
    busWrite(ad(2'd0, 2), arg);
    busWrite(ad(2'd0, 3), ~arg);
    busWrite(ad(2'd0, 0), {24'h0, vbit, 1'b0, op});
  endtask

  // polls word 0 of a response slot once per cycle after the verb write
  task automatic pollSlot(input logic slot, output int cyc, output logic [31:0] firstVal);
    logic [31:0] d;
    cyc = 0;
    firstVal = 'x;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cyc++;
      rd(ad(slot ? 2'd2 : 2'd1, 0), d);
      if (cyc == 1) firstVal = d;
      if (d != 0) break;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [31:0] first;
    logic [7:0]  prevVerb [2];
    int          cyc;

    prevVerb[0] = 8'h00;
    prevVerb[1] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of all slots
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < SLOT_WORDS; w++) begin
        rd(ad(2'(r), w), d);
        check("R1 reset word", d, 32'h0);
      end
    end

    // Vector walk
    for (int i = 0; i < 5; i++) begin
      logic vb;
      logic [31:0] base;
      vb = ~i[0];
      issueCmd(vb, VECS[i].op, VECS[i].arg);
      pollSlot(VECS[i].slot, cyc, first);
      check("R3 completion latency", 32'(cyc), 32'(LATENCY + 1));
      check("R5 target verb cleared", first, 32'h0);
      rd(ad(VECS[i].slot ? 2'd1 : 2'd2, 0), d);
      check("R5 other slot kept", d, {24'h0, prevVerb[~VECS[i].slot]});
      base = {30'h0, VECS[i].slot ? 2'd2 : 2'd1, 2'd0} & 32'h0;
      rd(ad(VECS[i].slot ? 2'd2 : 2'd1, 0), d);
      if (i == 0) check("R1 first result in slot 1", d, {24'h0, VECS[i].verb});
      check("R4 R6 verb in expected slot", d, {24'h0, VECS[i].verb} | base);
      rd(ad(VECS[i].slot ? 2'd2 : 2'd1, 1), d);
      check("R7 completion count", d, 32'(i + 1));
      rd(ad(VECS[i].slot ? 2'd2 : 2'd1, 2), d);
      check("R7 echo word 2", d, VECS[i].arg);
      rd(ad(VECS[i].slot ? 2'd2 : 2'd1, 3), d);
      check("R7 echo word 3", d, ~VECS[i].arg);
      prevVerb[VECS[i].slot] = VECS[i].verb;
    end

    // R2: same valid bit (1) with a new opcode starts nothing
    busWrite(ad(2'd0, 0), 32'h0000_00A2);
    repeat (LATENCY + 4) @(negedge clk);
    rd(ad(2'd1, 0), d);
    check("R2 slot 0 unchanged", d, 32'h0000_006A);
    rd(ad(2'd2, 0), d);
    check("R2 slot 1 unchanged", d, 32'h0000_00C1);
    rd(ad(2'd2, 1), d);
    check("R2 count unchanged", d, 32'd5);

    // R8: write to the command slot during execution is dropped
    issueCmd(1'b0, 6'h05, 32'h0000_0055);
    busWrite(ad(2'd0, 2), 32'hBAD0_BAD0);
    repeat (LATENCY + 3) @(negedge clk);
    rd(ad(2'd0, 2), d);
    check("R8 command word kept", d, 32'h0000_0055);
    rd(ad(2'd1, 2), d);
    check("R8 echo uses accepted word", d, 32'h0000_0055);
    rd(ad(2'd1, 0), d);
    check("R6 verb with clear valid bit", d, 32'h0000_0045);
    rd(ad(2'd1, 1), d);
    check("R7 count after six", d, 32'd6);

    // R9: response slots ignore bus writes
    busWrite(ad(2'd2, 1), 32'hDEAD_BEEF);
    rd(ad(2'd2, 1), d);
    check("R9 slot 1 word 1 kept", d, 32'd5);
    busWrite(ad(2'd1, 0), 32'h0);
    rd(ad(2'd1, 0), d);
    check("R9 slot 0 verb kept", d, 32'h0000_0045);

    // R10: region 3 reads zero
    for (int w = 0; w < SLOT_WORDS; w++) begin
      rd(ad(2'd3, w), d);
      check("R10 unused region", d, 32'h0);
    end

    // R1: reset again, first result returns to slot 1
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(ad(2'd1, 0), d);
    check("R1 slot 0 cleared by reset", d, 32'h0);
    rd(ad(2'd0, 2), d);
    check("R1 command cleared by reset", d, 32'h0);
    issueCmd(1'b1, 6'h0A, 32'h0000_0077);
    pollSlot(1'b1, cyc, first);
    check("R1 R3 latency after reset", 32'(cyc), 32'(LATENCY + 1));
    rd(ad(2'd2, 0), d);
    check("R1 result in slot 1", d, 32'h0000_00CA);
    rd(ad(2'd2, 1), d);
    check("R7 count restarts", d, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule